// File: doc/BRIEF.md
# Long-Press Reset Qualifier

This block turns an active-low pushbutton into a system reset request, but only after the button has been held down continuously for a selectable hold-down time. A single high sample during the hold restarts the qualification from zero, so contact bounce and brief taps never produce a request. The block runs from a fast system clock, and a separate enable tick from a slow free-running time base (nominally 8 kHz) advances the hold counter. One tick is one unit of hold time.

The hold-down time is picked by a 3-bit select input. Each step doubles the delay. With an 8 kHz tick and a base of 2500 ticks, the settings run from about 0.3125 s to 40 s. The select is captured only while the block is idle and sees the button released, so changing it during a press does not affect that press. When the hold time is reached, the block raises a level request that stays high until the button is released. It also issues a one-clock pulse on entry. The downstream reset sequencer shapes the reset pulse that follows.

Top module: `lpr_hold_timer`

## Requirements
- R1: Synchronous reset (`srst` high) clears `req_level` and `req_pulse` to 0 on the next clock edge. It also returns the hold counter to idle and loads the hold select with the default, code 5 (the 10 s setting, 32 × base).
- R2: `btn_n` passes through two synchronising flops, which reset to 1 (released), before any other logic uses it. A level applied before clock edge k is first seen by the hold logic at the tick on edge k+2.
- R3: The terminal count is BASE_TICKS × 2^sel for select codes 0 to 7, where code 0 is the shortest and each code doubles the one before. `req_level` rises on the tick that takes the number of consecutive low samples to the terminal count.
- R4: A high sample seen at any tick before the terminal count clears the count to zero. Input that never stays low for the full terminal count never raises a request.
- R5: `req_pulse` is high for exactly one clock, on the edge where `req_level` rises. `req_level` stays high until a high (released) sample is seen at a tick.
- R6: While the button stays held after a request, no second pulse occurs and `req_level` stays high. A new request needs a release followed by a full new hold.
- R7: `dly_sel` is captured only on ticks where the block is idle and the sample is high. A change made during a hold or while the request is high takes effect on the next press.
- R8: Clocks with `tick_en` low do not advance the counter, capture the select, or change `req_level`.
- R9: If the first press after reset begins before any idle released tick, it uses the default select (code 5) whatever `dly_sel` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| srst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time-base enable, one hold-time unit per high cycle |
| btn_n | input | 1 | Raw pushbutton level, low when pressed |
| dly_sel | input | 3 | Hold-down select, terminal = base × 2^code |
| req_pulse | output | 1 | One-clock user-reset request strobe |
| req_level | output | 1 | User-reset request held until release |

## Verification
The bench drives bounce patterns that fall one sample short of the terminal count. A counter that fails to clear on a high sample would raise a request there. Long holds that run well past the terminal count expose a design that re-arms without a release and pulses again. The select is changed in the middle of a hold, which catches a design that samples it continuously: such a design would fire at the new delay instead of the captured one. A press is also started right after reset with the tick held off, which shows whether the default setting is used. A design with the wrong synchroniser depth or wrong tick gating fires one or more cycles away from the reference model's edge.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   typedef enum logic [1:0] {
      HT_IDLE  = 2'd0,
      HT_COUNT = 2'd1,
      HT_FIRED = 2'd2
   } ht_state_e;

   // Largest terminal count reachable with a given base and select width.
   function automatic longint unsigned max_term(input int unsigned base, input int unsigned sel_w);
      return longint'(base) << ((1 << sel_w) - 1);
   endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic srst,
   input  logic d_async,
   output logic q_sync
);

   initial begin
      if (STAGES < 2) $error("lpr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (srst) chain_q[0] <= RST_LEVEL;
      else      chain_q[0] <= d_async;
   end

   for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
         if (srst) chain_q[gi] <= RST_LEVEL;
         else      chain_q[gi] <= chain_q[gi-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lpr_term_sel.sv
module lpr_term_sel #(
   parameter int unsigned BASE_TICKS = 2500,
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned CNT_W      = 19,
   parameter bit          USE_TABLE  = 1'b0
) (
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] term
);

   localparam int unsigned N_SEL = 1 << SEL_W;

   if (USE_TABLE) begin : g_table
      logic [CNT_W-1:0] tbl [N_SEL];
      for (genvar gi = 0; gi < N_SEL; gi++) begin : g_ent
         assign tbl[gi] = CNT_W'(longint'(BASE_TICKS) << gi);
      end
      assign term = tbl[sel];
   end else begin : g_shift
      assign term = CNT_W'(BASE_TICKS) << sel;
   end

endmodule

// File: rtl/lpr_hold_fsm.sv
module lpr_hold_fsm
   import lpr_pkg::*;
#(
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned CNT_W       = 19,
   parameter int unsigned DEFAULT_SEL = 5
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             tick_en,
   input  logic             lvl_hi,
   input  logic [SEL_W-1:0] dly_sel,
   input  logic [CNT_W-1:0] term,
   output logic [SEL_W-1:0] sel_q,
   output logic [CNT_W-1:0] cnt_q,
   output ht_state_e        state_q,
   output logic             pulse_q
);

   logic [CNT_W-1:0] cnt_inc;
   assign cnt_inc = cnt_q + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (srst) begin
         state_q <= HT_IDLE;
         cnt_q   <= '0;
         sel_q   <= SEL_W'(DEFAULT_SEL);
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (tick_en) begin
            unique case (state_q)
               HT_IDLE: begin
                  if (lvl_hi) begin
                     sel_q <= dly_sel;
                     cnt_q <= '0;
                  end else begin
                     cnt_q   <= CNT_W'(1);
                     state_q <= HT_COUNT;
                  end
               end
               HT_COUNT: begin
                  if (lvl_hi) begin
                     cnt_q   <= '0;
                     state_q <= HT_IDLE;
                  end else if (cnt_inc == term) begin
                     cnt_q   <= '0;
                     state_q <= HT_FIRED;
                     pulse_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_inc;
                  end
               end
               HT_FIRED: begin
                  if (lvl_hi) state_q <= HT_IDLE;
               end
               default: begin
                  state_q <= HT_IDLE;
                  cnt_q   <= '0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/lpr_hold_timer.sv
module lpr_hold_timer
   import lpr_pkg::*;
#(
   parameter int unsigned BASE_TICKS  = 2500,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned DEFAULT_SEL = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          USE_TABLE   = 1'b0
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             tick_en,
   input  logic             btn_n,
   input  logic [SEL_W-1:0] dly_sel,
   output logic             req_pulse,
   output logic             req_level
);

   localparam longint unsigned MAX_TERM = max_term(BASE_TICKS, SEL_W);
   localparam int unsigned     CNT_W    = $clog2(MAX_TERM + 1);

   initial begin
      if (BASE_TICKS < 2) $error("lpr_hold_timer: BASE_TICKS must be at least 2");
      if (DEFAULT_SEL >= (1 << SEL_W)) $error("lpr_hold_timer: DEFAULT_SEL out of range");
      if (SEL_W > 5) $error("lpr_hold_timer: SEL_W too large for counter");
   end

   logic             lvl_hi;
   logic [SEL_W-1:0] sel_cur;
   logic [CNT_W-1:0] cnt_cur;
   logic [CNT_W-1:0] term_cur;
   ht_state_e        st_cur;
   logic             pulse_cur;

   lpr_sync #(
      .STAGES    (SYNC_STAGES),
      .RST_LEVEL (1'b1)
   ) u_sync (
      .clk     (clk),
      .srst    (srst),
      .d_async (btn_n),
      .q_sync  (lvl_hi)
   );

   lpr_term_sel #(
      .BASE_TICKS (BASE_TICKS),
      .SEL_W      (SEL_W),
      .CNT_W      (CNT_W),
      .USE_TABLE  (USE_TABLE)
   ) u_term (
      .sel  (sel_cur),
      .term (term_cur)
   );

   lpr_hold_fsm #(
      .SEL_W       (SEL_W),
      .CNT_W       (CNT_W),
      .DEFAULT_SEL (DEFAULT_SEL)
   ) u_fsm (
      .clk     (clk),
      .srst    (srst),
      .tick_en (tick_en),
      .lvl_hi  (lvl_hi),
      .dly_sel (dly_sel),
      .term    (term_cur),
      .sel_q   (sel_cur),
      .cnt_q   (cnt_cur),
      .state_q (st_cur),
      .pulse_q (pulse_cur)
   );

   assign req_level = (st_cur == HT_FIRED);
   assign req_pulse = pulse_cur;

endmodule

// File: rtl/lpr_hold_timer_chk.sv
module lpr_hold_timer_chk
   import lpr_pkg::*;
#(
   parameter int unsigned SEL_W = 3,
   parameter int unsigned CNT_W = 19
) (
   input logic             clk,
   input logic             srst,
   input logic             tick_en,
   input logic             btn_n,
   input logic             req_pulse,
   input logic             req_level,
   input logic [SEL_W-1:0] sel_cur,
   input logic [CNT_W-1:0] cnt_cur,
   input logic [CNT_W-1:0] term_cur,
   input ht_state_e        st_cur
);

   logic [1:0] age = 2'd0;
   always_ff @(posedge clk) begin
      if (srst)              age <= 2'd0;
      else if (age != 2'd3)  age <= age + 2'd1;
   end

   logic ready;
   assign ready = (age == 2'd3);

   a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (srst || !ready)
      req_pulse |=> !req_pulse);

   a_r5_pulse_with_level: assert property (@(posedge clk) disable iff (srst || !ready)
      req_pulse |-> req_level);

   a_r5_rise_has_pulse: assert property (@(posedge clk) disable iff (srst || !ready)
      $rose(req_level) |-> req_pulse);

   a_r8_no_tick_frozen: assert property (@(posedge clk) disable iff (srst || !ready)
      !tick_en |=> ($stable(req_level) && $stable(cnt_cur) && $stable(sel_cur)));

   a_r4_count_below_term: assert property (@(posedge clk) disable iff (srst || !ready)
      cnt_cur < term_cur);

   a_r7_sel_frozen_busy: assert property (@(posedge clk) disable iff (srst || !ready)
      (st_cur != HT_IDLE) |=> $stable(sel_cur));

   a_r6_hold_keeps_request: assert property (@(posedge clk) disable iff (srst || !ready)
      (req_level && !btn_n && $past(!btn_n) && $past(!btn_n, 2)) |=> req_level);

endmodule

bind lpr_hold_timer lpr_hold_timer_chk #(
   .SEL_W (SEL_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .srst      (srst),
   .tick_en   (tick_en),
   .btn_n     (btn_n),
   .req_pulse (req_pulse),
   .req_level (req_level),
   .sel_cur   (sel_cur),
   .cnt_cur   (cnt_cur),
   .term_cur  (term_cur),
   .st_cur    (st_cur)
);

// File: tb/lpr_hold_timer_bench.sv
module lpr_hold_timer_bench;

   localparam int BASE = 3;
   localparam int DEF  = 5;

   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic       tick_en = 1'b0;
   logic       btn_n = 1'b1;
   logic [2:0] dly_sel = 3'd0;
   logic       req_pulse;
   logic       req_level;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural reference state
   int m_s1 = 1, m_s2 = 1, m_st = 0, m_run = 0, m_sel = DEF, m_pulse = 0;
   int pulses_seen = 0;

   always #4 clk = ~clk;

   lpr_hold_timer #(
      .BASE_TICKS  (BASE),
      .SEL_W       (3),
      .DEFAULT_SEL (DEF),
      .SYNC_STAGES (2),
      .USE_TABLE   (1'b0)
   ) u_lpr_hold_timer (
      .clk       (clk),
      .srst      (srst),
      .tick_en   (tick_en),
      .btn_n     (btn_n),
      .dly_sel   (dly_sel),
      .req_pulse (req_pulse),
      .req_level (req_level)
   );

   task automatic check(input string tag, input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic b, input logic t, input logic [2:0] s, input logic r, input string tag);
      int old_s2;
      @(negedge clk);
      btn_n = b; tick_en = t; dly_sel = s; srst = r;
      if (r) begin
         m_s1 = 1; m_s2 = 1; m_st = 0; m_run = 0; m_sel = DEF; m_pulse = 0;
      end else begin
         old_s2 = m_s2;
         m_s2 = m_s1;
         m_s1 = b;
         m_pulse = 0;
         if (t) begin
            if (m_st == 0) begin
               if (old_s2 == 1) m_sel = s;
               else begin m_run = 1; m_st = 1; end
            end else if (m_st == 1) begin
               if (old_s2 == 1) begin m_run = 0; m_st = 0; end
               else begin
                  m_run++;
                  if (m_run == (BASE << m_sel)) begin m_st = 2; m_pulse = 1; m_run = 0; end
               end
            end else begin
               if (old_s2 == 1) m_st = 0;
            end
         end
      end
      @(posedge clk);
      #1;
      if (req_pulse === 1'b1) pulses_seen++;
      check(tag, req_level, (m_st == 2), "req_level");
      check(tag, req_pulse, (m_pulse == 1), "req_pulse");
   endtask

   task automatic hold(input int n, input logic b, input logic [2:0] s, input string tag);
      for (int i = 0; i < n; i++) step(b, 1'b1, s, 1'b0, tag);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int p0;
      // R1: reset state, button held low through reset
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'd0, 1'b1, "R1");
      // R9: tick off while synchroniser fills, so first tick sees a press
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'd0, 1'b0, "R9");
      p0 = pulses_seen;
      hold(BASE * 32 - 1, 1'b0, 3'd0, "R9");
      check("R9", req_level, 1'b0, "level one tick before default terminal");
      hold(1, 1'b0, 3'd0, "R9");
      check("R9", req_level, 1'b1, "level at default terminal");
      check("R5", pulses_seen - p0, 1'b1, "single pulse");
      // R6: keep holding, no second pulse
      p0 = pulses_seen;
      hold(60, 1'b0, 3'd0, "R6");
      check("R6", pulses_seen == p0, 1'b1, "no repeat pulse while held");
      check("R6", req_level, 1'b1, "level kept while held");
      hold(4, 1'b1, 3'd0, "R5");
      check("R5", req_level, 1'b0, "level cleared on release");
      // R3/R2: every select code with exact terminal
      for (int s = 0; s < 8; s++) begin
         hold(3, 1'b1, 3'(s), "R3");
         hold(2 + (BASE << s) - 1, 1'b0, 3'(s), "R2");
         check("R3", req_level, 1'b0, "one tick short");
         hold(1, 1'b0, 3'(s), "R3");
         check("R3", req_level, 1'b1, "at terminal");
         hold(3, 1'b1, 3'(s), "R3");
      end
      // R4: bounce always one short of terminal (sel 1 -> 6)
      hold(3, 1'b1, 3'd1, "R4");
      p0 = pulses_seen;
      for (int k = 0; k < 20; k++) begin
         hold(BASE * 2 - 1, 1'b0, 3'd1, "R4");
         hold(1, 1'b1, 3'd1, "R4");
      end
      check("R4", pulses_seen == p0, 1'b1, "bounce raised no request");
      hold(4, 1'b1, 3'd1, "R4");
      for (int k = 0; k < 300; k++) step(($urandom_range(0, 3) == 0), 1'b1, 3'd1, 1'b0, "R4");
      hold(4, 1'b1, 3'd0, "R4");
      // R7: select change mid-hold ignored until next press
      hold(2, 1'b1, 3'd0, "R7");
      hold(3, 1'b0, 3'd0, "R7");
      hold(BASE - 2, 1'b0, 3'd3, "R7");
      check("R7", req_level, 1'b0, "captured code 0 not yet done");
      hold(1, 1'b0, 3'd3, "R7");
      check("R7", req_level, 1'b1, "fired at captured code 0");
      hold(4, 1'b1, 3'd3, "R7");
      hold(2 + BASE * 8, 1'b0, 3'd3, "R7");
      check("R7", req_level, 1'b1, "next press uses code 3");
      hold(4, 1'b1, 3'd1, "R7");
      // R8: sparse ticks
      for (int i = 0; i < 80; i++) step(1'b0, (i % 3 == 0), 3'd1, 1'b0, "R8");
      for (int i = 0; i < 12; i++) step(1'b1, (i % 4 == 0), 3'd1, 1'b0, "R8");
      // R1: reset mid-hold
      hold(3, 1'b1, 3'd2, "R1");
      hold(8, 1'b0, 3'd2, "R1");
      step(1'b0, 1'b1, 3'd2, 1'b1, "R1");
      check("R1", req_level, 1'b0, "level after reset");
      hold(BASE * 32 + 6, 1'b0, 3'd2, "R1");
      hold(4, 1'b1, 3'd2, "R1");
      summary();
   end

endmodule